// File: doc/BRIEF.md
# Shared-Vector Interrupt Controller

This block sits next to a small processor core and decides which interrupt the core should take next. It collects internal event pulses and external pin levels. External pins pass through a two-flop synchronizer and a per-pin edge detector whose polarity software picks. Where two sources share one vector slot, a selection register decides which of them feeds the slot. Each slot keeps a request bit and an enable bit behind a small register port.

Requests that are pending and enabled are ranked by a fixed priority, and the winner is offered to the core as a valid flag plus a vector number. When the core acknowledges, the winning request is cleared and the block pulses a signal that tells the core to set its interrupt-disable flag. A reset interrupt and a software break interrupt outrank all maskable slots and ignore every mask.

Changing an edge polarity, the alternate-pin switch or a source-selection bit can raise a request by itself. The block models this on purpose, so software has to mask the slot, change the setting, wait, clear the request and then unmask the slot.

Top module: `shared_vector_icu`

## Requirements
- R1: After reset the request, enable, selection, polarity and pin-switch registers read 0, and irq_valid and set_iflag are 0.
- R2: A one-cycle pulse on int_evt[j] sets a slot's request bit at the next clock edge, and the bit then stays set. Slot 9+j takes int_evt[j] for j = 0..6 while selection bit j+1 is 0.
- R3: Register addresses are 0 request, 1 enable, 2 selection, 3 polarity and 4 pin switch (bit 0). Enable bits read back what was written. A write to the request register clears each bit written as 0 and leaves each bit written as 1 unchanged, so software can never set a request.
- R4: A maskable slot is offered only when its request bit and enable bit are both 1 and cpu_iflag is 0.
- R5: Among the offered maskable slots the lowest index wins, and irq_vec = 2 + slot index.
- R6: A reset_evt pulse (vector 0) outranks a brk_evt pulse (vector 1), and both outrank every maskable slot. Neither depends on enable bits or cpu_iflag.
- R7: When irq_ack is high while irq_valid is 1, set_iflag is 1 in that cycle and the winner's pending state clears at the clock edge. When irq_ack is high while irq_valid is 0, nothing changes.
- R8: If the acknowledged slot's own event arrives in the acknowledge cycle, its request bit stays set.
- R9: The top eight slots (8..15) are shared. Selection bit k picks the alternate source for slot 8+k when it is 1. The alternate source for slot 8+k is int_evt[7 + (k mod 6)]. The source that is not selected has no effect.
- R10: A write that changes selection bit k sets the request bit of slot 8+k.
- R11: External pin e drives slot e. Polarity bit 1 selects the rising edge and 0 selects the falling edge. The request bit is set at the third clock edge after the pin changes.
- R12: Changing polarity bit e sets request e when the pin is high and the bit goes from 0 to 1, or when the pin is low and the bit goes from 1 to 0.
- R13: Pin-switch bit 1 routes ext_alt_pin[0] to external input 0 and ext_alt_pin[1] to external input 4, instead of ext_pin[0] and ext_pin[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 9 | Primary external interrupt pins |
| ext_alt_pin | input | 2 | Alternate pins for external inputs 0 and 4 |
| int_evt | input | 13 | Internal event pulses |
| reset_evt | input | 1 | Reset interrupt event |
| brk_evt | input | 1 | Software break event |
| cpu_iflag | input | 1 | Core interrupt-disable flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vec | output | 5 | Offered vector number |
| irq_ack | input | 1 | Core accepts the offered vector |
| set_iflag | output | 1 | Core should set its disable flag |

## Verification
A request bit that is lost or wrongly set shows up in the request register readback at once, and in irq_vec in the same cycle once the slot is enabled. A fault in the edge detector or the synchronizer moves the request by one or more clock edges from the third edge after the pin changes, so the bench samples on both sides of that edge. A broken selection path lets the unselected source set the slot, or keeps the selected one from setting it, and this is visible one edge after the pulse. A fault in acknowledge handling leaves a served slot pending, or wrongly clears a slot whose event arrived in the acknowledge cycle, and the vector sequence seen across repeated acknowledges exposes it.

// File: rtl/icu_pkg.sv
package icu_pkg;
   localparam logic [2:0] RA_REQ = 3'd0;
   localparam logic [2:0] RA_EN  = 3'd1;
   localparam logic [2:0] RA_SEL = 3'd2;
   localparam logic [2:0] RA_POL = 3'd3;
   localparam logic [2:0] RA_PIN = 3'd4;

   localparam int VEC_RST  = 0;
   localparam int VEC_BRK  = 1;
   localparam int VEC_BASE = 2;

   // Alternate source index for shared slot k: sources above the slot count, reused cyclically
   function automatic int alt_src(input int k, input int nsrc, input int nvec);
      return nvec + (k % (nsrc - nvec));
   endfunction
endpackage

// File: rtl/icu_edge_unit.sv
module icu_edge_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic pol,
   output logic evt
);
   logic sync1_q, sync2_q, act_q;
   logic act;

   // Polarity folded into the level; a polarity change is seen as a level step
   assign act = pol ? sync2_q : ~sync2_q;
   assign evt = act & ~act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= 1'b0;
         sync2_q <= 1'b0;
         act_q   <= 1'b1;
      end else begin
         sync1_q <= pin_in;
         sync2_q <= sync1_q;
         act_q   <= act;
      end
   end

   p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/icu_src_route.sv
module icu_src_route #(
   parameter int NVEC = 16,
   parameter int NSRC = 22,
   parameter int NSHR = 8
) (
   input  logic [NSRC-1:0] src,
   input  logic [NSHR-1:0] sel_q,
   input  logic            sel_wr,
   input  logic [NSHR-1:0] sel_wdata,
   output logic [NVEC-1:0] slot_evt
);
   localparam int FIRST_SHR = NVEC - NSHR;

   for (genvar s = 0; s < NVEC; s++) begin : g_slot
      if (s < FIRST_SHR) begin : g_direct
         assign slot_evt[s] = src[s];
      end else begin : g_shared
         localparam int K   = s - FIRST_SHR;
         localparam int ALT = icu_pkg::alt_src(K, NSRC, NVEC);
         logic picked, sel_flip;
         assign picked      = sel_q[K] ? src[ALT] : src[s];
         assign sel_flip    = sel_wr & (sel_wdata[K] ^ sel_q[K]);
         assign slot_evt[s] = picked | sel_flip;
      end
   end
endmodule

// File: rtl/icu_prio_pick.sv
module icu_prio_pick #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     grant
);
   assign any   = |pend;
   assign grant = pend & (~pend + N'(1));

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

   p_grant_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (grant[idx] && $onehot0(grant)));
endmodule

// File: rtl/shared_vector_icu.sv
module shared_vector_icu #(
   parameter int NVEC     = 16,
   parameter int NEXT     = 9,
   parameter int NINT     = 13,
   parameter int NSHR     = 8,
   parameter int DATA_W   = 16,
   parameter int ALT_IDX0 = 0,
   parameter int ALT_IDX1 = 4,
   parameter int VID_W    = $clog2(NVEC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEXT-1:0]   ext_pin,
   input  logic [1:0]        ext_alt_pin,
   input  logic [NINT-1:0]   int_evt,
   input  logic              reset_evt,
   input  logic              brk_evt,
   input  logic              cpu_iflag,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_valid,
   output logic [VID_W-1:0]  irq_vec,
   input  logic              irq_ack,
   output logic              set_iflag
);
   import icu_pkg::*;

   localparam int NSRC  = NEXT + NINT;
   localparam int IDX_W = $clog2(NVEC);

   if (NSRC <= NVEC)       begin : g_chk_src   $error("need more sources than slots");  end
   if (NSHR > NVEC)        begin : g_chk_shr   $error("too many shared slots");         end
   if (NVEC > DATA_W)      begin : g_chk_vw    $error("slots exceed data width");       end
   if (NEXT > DATA_W)      begin : g_chk_ew    $error("pins exceed data width");        end
   if (NEXT > NVEC)        begin : g_chk_ev    $error("pins exceed slots");             end
   if (ALT_IDX0 >= NEXT || ALT_IDX1 >= NEXT || ALT_IDX0 == ALT_IDX1)
                           begin : g_chk_alt   $error("bad alternate pin index");       end

   logic [NVEC-1:0] req_q, en_q;
   logic [NSHR-1:0] sel_q;
   logic [NEXT-1:0] pol_q;
   logic            pin_sw_q, rst_pend_q, brk_pend_q;

   logic wr_req, wr_en, wr_sel, wr_pol, wr_pin;
   assign wr_req = reg_we && (reg_addr == RA_REQ);
   assign wr_en  = reg_we && (reg_addr == RA_EN);
   assign wr_sel = reg_we && (reg_addr == RA_SEL);
   assign wr_pol = reg_we && (reg_addr == RA_POL);
   assign wr_pin = reg_we && (reg_addr == RA_PIN);

   // External path: pin choice, synchronizer, edge detection
   logic [NEXT-1:0] pin_mux, ext_evt;
   for (genvar e = 0; e < NEXT; e++) begin : g_ext
      if (e == ALT_IDX0) begin : g_alt0
         assign pin_mux[e] = pin_sw_q ? ext_alt_pin[0] : ext_pin[e];
      end else if (e == ALT_IDX1) begin : g_alt1
         assign pin_mux[e] = pin_sw_q ? ext_alt_pin[1] : ext_pin[e];
      end else begin : g_plain
         assign pin_mux[e] = ext_pin[e];
      end
      icu_edge_unit i_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_in (pin_mux[e]),
         .pol    (pol_q[e]),
         .evt    (ext_evt[e])
      );
   end

   logic [NSRC-1:0] src;
   logic [NVEC-1:0] slot_evt;
   assign src = {int_evt, ext_evt};

   icu_src_route #(.NVEC(NVEC), .NSRC(NSRC), .NSHR(NSHR)) i_route (
      .src       (src),
      .sel_q     (sel_q),
      .sel_wr    (wr_sel),
      .sel_wdata (reg_wdata[NSHR-1:0]),
      .slot_evt  (slot_evt)
   );

   // Arbitration
   logic [NVEC-1:0]  pend, m_grant;
   logic             m_any;
   logic [IDX_W-1:0] m_idx;
   assign pend = req_q & en_q & {NVEC{~cpu_iflag}};

   icu_prio_pick #(.N(NVEC)) i_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .any   (m_any),
      .idx   (m_idx),
      .grant (m_grant)
   );

   logic take, take_mask;
   assign irq_valid = rst_pend_q | brk_pend_q | m_any;
   assign take      = irq_ack & irq_valid;
   assign take_mask = take & ~rst_pend_q & ~brk_pend_q;
   assign set_iflag = take;

   always_comb begin
      if (rst_pend_q)      irq_vec = VID_W'(VEC_RST);
      else if (brk_pend_q) irq_vec = VID_W'(VEC_BRK);
      else                 irq_vec = VID_W'(VEC_BASE) + VID_W'(m_idx);
   end

   logic [NVEC-1:0] sw_keep, ack_clr, req_nxt;
   assign sw_keep = wr_req ? reg_wdata[NVEC-1:0] : '1;
   assign ack_clr = take_mask ? m_grant : '0;
   assign req_nxt = (req_q & sw_keep & ~ack_clr) | slot_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         en_q       <= '0;
         sel_q      <= '0;
         pol_q      <= '0;
         pin_sw_q   <= 1'b0;
         rst_pend_q <= 1'b0;
         brk_pend_q <= 1'b0;
      end else begin
         req_q      <= req_nxt;
         rst_pend_q <= reset_evt | (rst_pend_q & ~take);
         brk_pend_q <= brk_evt | (brk_pend_q & ~(take & ~rst_pend_q));
         if (wr_en)  en_q     <= reg_wdata[NVEC-1:0];
         if (wr_sel) sel_q    <= reg_wdata[NSHR-1:0];
         if (wr_pol) pol_q    <= reg_wdata[NEXT-1:0];
         if (wr_pin) pin_sw_q <= reg_wdata[0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_REQ:  reg_rdata[NVEC-1:0] = req_q;
         RA_EN:   reg_rdata[NVEC-1:0] = en_q;
         RA_SEL:  reg_rdata[NSHR-1:0] = sel_q;
         RA_POL:  reg_rdata[NEXT-1:0] = pol_q;
         RA_PIN:  reg_rdata[0]        = pin_sw_q;
         default: reg_rdata           = '0;
      endcase
   end

   p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !rst_pend_q && !brk_pend_q) |-> (!cpu_iflag && |(req_q & en_q)));

   p_rst_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pend_q |-> (irq_valid && irq_vec == VID_W'(VEC_RST)));

   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_mask && !(|(slot_evt & m_grant))) |=> !(|(req_q & $past(m_grant))));

   p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_mask && |(slot_evt & m_grant)) |=> |(req_q & $past(m_grant)));

   for (genvar b = 0; b < NVEC; b++) begin : g_req_chk
      p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_q[b]) |-> $past(slot_evt[b]));
   end
endmodule

// File: tb/test_shared_vector_icu.sv
`timescale 1ns/1ps
module test_shared_vector_icu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  ext_pin = '0;
   logic [1:0]  ext_alt_pin = '0;
   logic [12:0] int_evt = '0;
   logic        reset_evt = 1'b0, brk_evt = 1'b0, cpu_iflag = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_valid, set_iflag, irq_ack = 1'b0;
   logic [4:0]  irq_vec;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   shared_vector_icu i_shared_vector_icu (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_alt_pin(ext_alt_pin),
      .int_evt(int_evt), .reset_evt(reset_evt), .brk_evt(brk_evt),
      .cpu_iflag(cpu_iflag), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
      .irq_vec(irq_vec), .irq_ack(irq_ack), .set_iflag(set_iflag)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic pulse_int(input logic [12:0] m);
      int_evt = m;
      tick();
      int_evt = '0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   function automatic int lowest(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return -1;
   endfunction

   logic [15:0] d;

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      tick(3);
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(0, d); chk("R1 req", d, 0);
      rd(1, d); chk("R1 en", d, 0);
      rd(2, d); chk("R1 sel", d, 0);
      rd(3, d); chk("R1 pol", d, 0);
      rd(4, d); chk("R1 pinsw", d, 0);
      chk("R1 valid", {irq_valid, set_iflag}, 0);

      // R2 internal event sets and holds
      pulse_int(13'h001);
      rd(0, d); chk("R2 slot9 set", d, 16'h0200);
      tick(3);
      rd(0, d); chk("R2 slot9 held", d, 16'h0200);

      // R4 gating
      chk("R4 no enable", irq_valid, 0);
      cpu_iflag = 1'b1;
      wr(1, 16'hFFFF);
      chk("R4 iflag masks", irq_valid, 0);
      cpu_iflag = 1'b0; #0.5;
      chk("R4 offered", irq_valid, 1);
      chk("R5 vec slot9", irq_vec, 11);

      // R3 register semantics
      wr(1, 16'hA5A5);
      rd(1, d); chk("R3 enable readback", d, 16'hA5A5);
      wr(1, 16'hFFFF);
      wr(0, 16'hFFFF);
      rd(0, d); chk("R3 write one keeps", d, 16'h0200);
      wr(0, 16'hFDFF);
      rd(0, d); chk("R3 write zero clears", d, 16'h0000);

      // R5 / R7 priority and acknowledge
      pulse_int(13'h009);
      chk("R5 lowest wins", irq_vec, 11);
      irq_ack = 1'b1; #0.5;
      chk("R7 set_iflag on ack", set_iflag, 1);
      tick(); irq_ack = 1'b0;
      chk("R7 next winner", irq_vec, 14);
      do_ack();
      chk("R7 all served", irq_valid, 0);

      // R7 ack without valid is ignored
      pulse_int(13'h001);
      cpu_iflag = 1'b1;
      irq_ack = 1'b1; #0.5;
      chk("R7 no pulse when idle", set_iflag, 0);
      tick(); irq_ack = 1'b0;
      rd(0, d); chk("R7 idle ack keeps req", d, 16'h0200);

      // R6 reset and break outrank, ignore masks
      reset_evt = 1'b1; brk_evt = 1'b1;
      tick();
      reset_evt = 1'b0; brk_evt = 1'b0;
      chk("R6 reset first", {irq_valid, irq_vec}, {1'b1, 5'd0});
      do_ack();
      chk("R6 break second", {irq_valid, irq_vec}, {1'b1, 5'd1});
      do_ack();
      chk("R6 then masked", irq_valid, 0);
      rd(0, d); chk("R6 slot kept", d, 16'h0200);
      cpu_iflag = 1'b0;

      // R8 event in acknowledge cycle wins
      #0.5; chk("R8 offered", irq_vec, 11);
      irq_ack = 1'b1; int_evt = 13'h001;
      tick();
      irq_ack = 1'b0; int_evt = '0;
      rd(0, d); chk("R8 request survives", d, 16'h0200);
      wr(0, 16'h0000);

      // R10 / R9 shared slot selection
      wr(2, 16'h0002);
      rd(0, d); chk("R10 select change sets", d, 16'h0200);
      wr(0, 16'h0000);
      pulse_int(13'h001);
      rd(0, d); chk("R9 unselected ignored", d, 16'h0000);
      pulse_int(13'h100);
      rd(0, d); chk("R9 alternate drives", d, 16'h0200);
      wr(2, 16'h0002);
      wr(0, 16'h0000);
      rd(0, d); chk("R10 same value no set", d, 16'h0000);
      wr(2, 16'h0000);
      wr(0, 16'h0000);

      // R11 rising edge on pin 2, three-edge latency
      wr(3, 16'h0004);
      wr(0, 16'h0000);
      ext_pin[2] = 1'b1;
      tick(2);
      rd(0, d); chk("R11 not yet", d, 16'h0000);
      tick(1);
      rd(0, d); chk("R11 rising seen", d, 16'h0004);
      wr(0, 16'h0000);
      ext_pin[2] = 1'b0;
      tick(4);
      rd(0, d); chk("R11 falling ignored", d, 16'h0000);

      // R11 falling edge on pin 3
      ext_pin[3] = 1'b1;
      tick(4);
      rd(0, d); chk("R11 rising ignored pol0", d, 16'h0000);
      ext_pin[3] = 1'b0;
      tick(2);
      rd(0, d); chk("R11 fall not yet", d, 16'h0000);
      tick(1);
      rd(0, d); chk("R11 falling seen", d, 16'h0008);
      wr(0, 16'h0000);

      // R12 polarity change with static pin
      ext_pin[5] = 1'b1;
      tick(4);
      rd(0, d); chk("R12 baseline", d, 16'h0000);
      wr(3, 16'h0024);
      tick(1);
      rd(0, d); chk("R12 0to1 high sets", d, 16'h0020);
      wr(0, 16'h0000);
      wr(3, 16'h0004);
      tick(2);
      rd(0, d); chk("R12 1to0 high quiet", d, 16'h0000);

      // R13 alternate pin for input 0
      wr(3, 16'h0005);
      wr(0, 16'h0000);
      ext_alt_pin[0] = 1'b1;
      tick(4);
      rd(0, d); chk("R13 alt unused", d, 16'h0000);
      ext_alt_pin[0] = 1'b0;
      tick(4);
      wr(4, 16'h0001);
      tick(4);
      rd(0, d); chk("R13 switch quiet", d, 16'h0000);
      ext_alt_pin[0] = 1'b1;
      tick(4);
      rd(0, d); chk("R13 alt drives", d, 16'h0001);
      wr(0, 16'h0000);

      // Random internal patterns, served in order (R2 R5 R7)
      for (int it = 0; it < 20; it++) begin
         logic [12:0] m;
         logic [15:0] exp;
         m = 13'($urandom);
         pulse_int(m);
         exp = {m[6:0], 9'h000};
         rd(0, d); chk("R2 random set", d, exp);
         while (exp != 0) begin
            chk("R5 random vector", {irq_valid, irq_vec}, {1'b1, 5'(2 + lowest(exp))});
            do_ack();
            exp &= exp - 16'd1;
         end
         chk("R7 random drained", irq_valid, 0);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule